// File: doc/BRIEF.md
# Peripheral Bus Address Decoder

This block turns a 17-bit byte address on a local peripheral bus into one-hot chip selects. There are five targets: a manager register file, a register window inside an FPGA, a palette DAC, an FM sound chip and a banked 16-bit SRAM. It is purely combinational. The bus controller presents the address, an access strobe and a bank number held in an external register. In the same cycle the block returns the select, the reduced register offset of the chosen target and the SRAM word address.

The lower 32 KiB of the address space is a 512-byte register area that repeats 64 times, so only the low nine address bits pick a register target. The upper part holds two SRAM windows. A 64 KiB window maps the whole of a bank. A 32 KiB window maps only the upper half of the same bank. Both windows take the bank number from `bank_i`.

Top module: `periph_addr_decode`

## Requirements
- R1: While `strobe_i` is low, `sel_o`, `reg_off_o` and `sram_addr_o` are all zero.
- R2: While `strobe_i` is high, exactly one bit of `sel_o` is set.
- R3: For addresses below 0x08000, bits [8:7] choose the target: 00 sets `sel_o[0]` (manager), 01 sets `sel_o[1]` (FPGA window), 10 sets `sel_o[2]` (palette DAC) and 11 sets `sel_o[3]` (sound chip).
- R4: Within 0x00000–0x07FFF, address bits [14:9] change neither `sel_o` nor `reg_off_o`, so every 512-byte mirror decodes like the base copy.
- R5: For the manager, `reg_off_o` is the zero-extended value of address bits [2:1]. Bit 0 is ignored, and the four registers repeat every 8 bytes.
- R6: For the FPGA window, `reg_off_o` equals address bits [6:0].
- R7: For the palette DAC, `reg_off_o` is the zero-extended value of address bits [2:1], with bit 0 ignored.
- R8: For the sound chip, `reg_off_o` is the zero-extended value of address bit [1], with bit 0 ignored.
- R9: For addresses 0x10000–0x1FFFF, `sel_o[4]` is set and `sram_addr_o` = {bank_i, A[15:1]}.
- R10: For addresses 0x08000–0x0FFFF, `sel_o[4]` is set and `sram_addr_o` = {bank_i, 1'b1, A[14:1]}.
- R11: `reg_off_o` is zero during an SRAM access, and `sram_addr_o` is zero during a register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 17 | Byte address on the local bus |
| strobe_i | input | 1 | Access in progress |
| bank_i | input | 2 | SRAM bank number from the external bank register |
| sel_o | output | 5 | One-hot select: [0] manager, [1] FPGA, [2] DAC, [3] sound, [4] SRAM |
| reg_off_o | output | 7 | Offset inside the selected register target |
| sram_addr_o | output | 17 | SRAM word address |

## Verification
Two folds can act on the same access: the mirror fold, which discards bits [14:9], and the bit-0 fold of the manager, DAC and sound targets. An odd address in a high mirror provokes both at once. The bench sweeps every address from 0x00000 to 0x1FFFF and derives the expected select, offset and SRAM address arithmetically from the requirements. A second fold pair tests the boundary at 0x08000. There, register decoding must hand over to the 32 KiB SRAM window, which forces bit 14 high in the word address. The bench judges both folds per address and varies the bank with the address, so a bank bit that leaks into the register path, or an address bit that leaks into the bank field, shows up as a mismatch.

// File: rtl/avdec_pkg.sv
package avdec_pkg;
  localparam int unsigned ADDR_W     = 17;
  localparam int unsigned BANK_W     = 2;
  localparam int unsigned AREA_W     = 9;  // register area before mirroring
  localparam int unsigned SPAN_W     = 7;  // bytes per register target
  localparam int unsigned OFF_W      = SPAN_W;
  localparam int unsigned N_REG_TGT  = 1 << (AREA_W - SPAN_W);
  localparam int unsigned N_TGT      = N_REG_TGT + 1;
  localparam int unsigned SRAM_AW    = BANK_W + ADDR_W - 2;

  typedef enum logic [AREA_W-SPAN_W-1:0] {
    TGT_MGR  = 2'd0,
    TGT_FPGA = 2'd1,
    TGT_DAC  = 2'd2,
    TGT_SND  = 2'd3
  } reg_tgt_e;

  localparam int unsigned MGR_OFF_W = 2;
  localparam int unsigned DAC_OFF_W = 2;
  localparam int unsigned SND_OFF_W = 1;
endpackage

// File: rtl/avdec_reg_area.sv
module avdec_reg_area
  import avdec_pkg::*;
(
  input  logic [AREA_W-1:0]    a_i,
  input  logic                 en_i,
  output logic [N_REG_TGT-1:0] sel_o,
  output logic [OFF_W-1:0]     off_o
);
  localparam int unsigned TGT_W = AREA_W - SPAN_W;

  reg_tgt_e tgt;
  assign tgt = reg_tgt_e'(a_i[AREA_W-1:SPAN_W]);

  for (genvar g = 0; g < N_REG_TGT; g++) begin : g_sel
    assign sel_o[g] = en_i && (a_i[AREA_W-1:SPAN_W] == TGT_W'(g));
  end

  always_comb begin
    off_o = '0;
    if (en_i) begin
      unique case (tgt)
        TGT_MGR:  off_o = OFF_W'(a_i[MGR_OFF_W:1]);
        TGT_FPGA: off_o = a_i[OFF_W-1:0];
        TGT_DAC:  off_o = OFF_W'(a_i[DAC_OFF_W:1]);
        TGT_SND:  off_o = OFF_W'(a_i[SND_OFF_W:1]);
        default:  off_o = '0;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({en_i, a_i})) begin
      assert_reg_onehot_R3: assert ($onehot0(sel_o));
      if (!en_i) assert_reg_off_idle_R11: assert (off_o == '0);
    end
  end
endmodule

// File: rtl/avdec_sram_map.sv
module avdec_sram_map
  import avdec_pkg::*;
(
  input  logic [ADDR_W-2:0]  wa_i,   // word address, byte bit dropped
  input  logic [BANK_W-1:0]  bank_i,
  input  logic               en_i,
  output logic               win_o,
  output logic               reg_area_o,
  output logic [SRAM_AW-1:0] addr_o
);
  logic big_win, small_win;

  assign big_win    = wa_i[ADDR_W-2];
  assign small_win  = !wa_i[ADDR_W-2] && wa_i[ADDR_W-3];
  assign win_o      = en_i && (big_win || small_win);
  assign reg_area_o = en_i && !big_win && !small_win;

  always_comb begin
    addr_o = '0;
    if (en_i && big_win)
      addr_o = {bank_i, wa_i[ADDR_W-3:0]};
    else if (en_i && small_win)
      addr_o = {bank_i, 1'b1, wa_i[ADDR_W-4:0]};
  end

  always_comb begin
    if (!$isunknown({en_i, wa_i, bank_i})) begin
      assert_win_excl_R2: assert (!(win_o && reg_area_o));
      if (en_i && small_win) assert_small_upper_R10: assert (addr_o[ADDR_W-3]);
    end
  end
endmodule

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
  import avdec_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               strobe_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic [N_TGT-1:0]   sel_o,
  output logic [OFF_W-1:0]   reg_off_o,
  output logic [SRAM_AW-1:0] sram_addr_o
);
  logic                 sram_sel, reg_en;
  logic [N_REG_TGT-1:0] reg_sel;

  avdec_sram_map u_sram (
    .wa_i       (addr_i[ADDR_W-1:1]),
    .bank_i     (bank_i),
    .en_i       (strobe_i),
    .win_o      (sram_sel),
    .reg_area_o (reg_en),
    .addr_o     (sram_addr_o)
  );

  avdec_reg_area u_reg (
    .a_i   (addr_i[AREA_W-1:0]),
    .en_i  (reg_en),
    .sel_o (reg_sel),
    .off_o (reg_off_o)
  );

  assign sel_o = {sram_sel, reg_sel};

  always_comb begin
    if (!$isunknown({addr_i, strobe_i, bank_i})) begin
      if (!strobe_i) assert_idle_quiet_R1: assert (sel_o == '0 && sram_addr_o == '0);
      if (strobe_i)  assert_one_sel_R2: assert ($countones(sel_o) == 1);
      if (sel_o[N_TGT-1]) assert_bank_field_R9: assert (sram_addr_o[SRAM_AW-1 -: BANK_W] == bank_i);
      if (sel_o[N_TGT-1]) assert_no_off_in_sram_R11: assert (reg_off_o == '0);
    end
  end
endmodule

// File: tb/periph_addr_decode_bench.sv
module periph_addr_decode_bench;
  logic        clk = 1'b0;
  logic [16:0] addr;
  logic        strobe;
  logic [1:0]  bank;
  logic [4:0]  sel;
  logic [6:0]  off;
  logic [16:0] saddr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  periph_addr_decode u_periph_addr_decode (
    .addr_i(addr), .strobe_i(strobe), .bank_i(bank),
    .sel_o(sel), .reg_off_o(off), .sram_addr_o(saddr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h bank=%0d stb=%0b act=%h exp=%h", req, addr, bank, strobe, act, exp);
    end
  endtask

  task automatic apply(int a, bit s);
    int b;
    int e_sel, e_off, e_sa;
    addr = 17'(a); strobe = s; bank = 2'(((a >> 4) ^ (a >> 11)) & 3);
    b = bank;
    @(negedge clk);
    e_sel = 0; e_off = 0; e_sa = 0;
    if (s) begin
      if (a >= 'h10000) begin
        e_sel = 16; e_sa = b * 32768 + ((a % 65536) / 2);             // R9
      end else if (a >= 'h8000) begin
        e_sel = 16; e_sa = b * 32768 + 16384 + ((a % 32768) / 2);     // R10
      end else begin
        case ((a % 512) / 128)                                         // R3, R4
          0: begin e_sel = 1; e_off = (a % 8) / 2; end                 // R5
          1: begin e_sel = 2; e_off = a % 128; end                     // R6
          2: begin e_sel = 4; e_off = (a % 8) / 2; end                 // R7
          default: begin e_sel = 8; e_off = (a % 4) / 2; end           // R8
        endcase
      end
    end
    if (!s) chk("R1", {sel, off, saddr}, 0);
    else if (a < 'h8000) begin
      chk("R3/R4", 32'(sel), 32'(e_sel));
      chk("R5-8", 32'(off), 32'(e_off));
      chk("R11", 32'(saddr), 0);
    end else begin
      chk("R2", 32'($countones(sel)), 1);
      chk(a >= 'h10000 ? "R9" : "R10", {sel, saddr}, {5'(e_sel), 17'(e_sa)});
      chk("R11", 32'(off), 0);
    end
  endtask

  initial begin
    addr = '0; strobe = 1'b0; bank = '0;
    @(negedge clk);
    chk("R1", {sel, off, saddr}, 0);
    for (int a = 0; a < 131072; a++) apply(a, 1'b1);
    for (int a = 0; a < 131072; a += 251) apply(a, 1'b0);
    // corner addresses: first and last mirror, odd bytes, window edges
    apply('h00007, 1'b1); apply('h07E07, 1'b1); apply('h07FFF, 1'b1);
    apply('h08000, 1'b1); apply('h0FFFF, 1'b1); apply('h10000, 1'b1);
    apply('h1FFFF, 1'b1); apply('h07F81, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule